// File: doc/BRIEF.md
# Keypad Door Code Lock

This block is a synchronous Moore state machine that guards a door. A keypad presents one 4-bit key code at a time, together with a strobe that is high for exactly one clock edge per press. The machine follows how far a fixed five-symbol access sequence has progressed. It drives a door-open output when the sequence completes and an alarm output when a wrong key arrives in night mode. In day mode a dedicated open key unlocks the door without the code.

Timeout timers sit outside the block. A timer that fires after a few seconds with no key press, or after the alarm has sounded for a while, drives the block's reset input and returns the machine to idle. The reset also serves as the power-up reset. Outputs come only from the registered state, so input activity between clock edges cannot glitch them. The nominal clock is 10 MHz.

Top module: `entry_lock`

## Requirements
- R1: Keys are 4-bit codes. Digits use their binary value, A is 1010, B is 1011 and the open key is 1111. Pressing 5, 3, A, 1, 7 in that order from idle raises `door_open` in the cycle after the strobe edge of the fifth key, and not before.
- R2: The key code and mode are sampled only on a clock edge where `key_stb` is high. Cycles without the strobe leave the state and both outputs unchanged.
- R3: In day mode (`night_mode` = 0), the open key 1111 moves the machine to the open state from any point of the entry sequence.
- R4: In night mode (`night_mode` = 1), any key that is not the next expected symbol moves the machine to the alarm state. This includes 1111.
- R5: In day mode, a wrong key that is not 1111 raises no alarm and restarts the sequence. The progress becomes one if that key is 5, and zero otherwise.
- R6: Once open, `door_open` stays high and `alarm` stays low until reset, whatever keys are pressed.
- R7: Once in alarm, `alarm` stays high and `door_open` stays low until reset, whatever keys are pressed.
- R8: `timeout_rst` is active-high and synchronous. A clock edge with it high returns the machine to idle, with both outputs low and no progress.
- R9: `door_open` and `alarm` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| timeout_rst | input | 1 | Synchronous active-high return to idle, driven by the external timers |
| key_stb | input | 1 | Key-valid strobe, high for one edge per press |
| night_mode | input | 1 | 1 for night mode, 0 for day mode |
| key_code | input | 4 | Code of the pressed key |
| door_open | output | 1 | High while in the open state |
| alarm | output | 1 | High while in the alarm state |

## Verification
The assertions check on every cycle that:
- the open and alarm states persist;
- idle cycles without a strobe leave the state alone;
- a night-mode mismatch leads to alarm, the day-mode open key leads to open, and a day-mode mismatch restarts the progress at the right value;
- reset clears everything.

Only the bench scenarios can show that the progress is correct at each position. The bench sweeps every key at every position in both modes, then finishes the remaining symbols in night mode and confirms that the door opens exactly on the last one. It also shows that the full five-key code, in its exact order, is what unlocks the door.

// File: rtl/entry_lock_pkg.sv
package entry_lock_pkg;
    typedef enum logic [1:0] {
        PH_ENTRY = 2'd0,
        PH_OPEN  = 2'd1,
        PH_ALARM = 2'd2
    } phase_e;
endpackage

// File: rtl/lock_key_match.sv
module lock_key_match #(
    parameter int KEY_W    = 4,
    parameter int CODE_LEN = 5,
    parameter int CNT_W    = 3,
    parameter logic [CODE_LEN*KEY_W-1:0] ACCESS_CODE = 20'h53A17,
    parameter logic [KEY_W-1:0] OPEN_KEY = 4'hF
) (
    input  logic [KEY_W-1:0] key,
    input  logic [CNT_W-1:0] pos,
    output logic             hit_pos,
    output logic             hit_first,
    output logic             hit_open
);
    localparam int SLOTS = 1 << CNT_W;

    // symbol expected at each progress value; first symbol sits in the top nibble
    logic [KEY_W-1:0] sym [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < CODE_LEN) begin : g_used
            assign sym[i] = ACCESS_CODE[(CODE_LEN-1-i)*KEY_W +: KEY_W];
        end else begin : g_pad
            assign sym[i] = '0;
        end
    end

    assign hit_pos   = (key == sym[pos]);
    assign hit_first = (key == sym[0]);
    assign hit_open  = (key == OPEN_KEY);
endmodule

// File: rtl/lock_seq_fsm.sv
module lock_seq_fsm
    import entry_lock_pkg::*;
#(
    parameter int CODE_LEN = 5,
    parameter int CNT_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_stb,
    input  logic             night,
    input  logic             hit_pos,
    input  logic             hit_first,
    input  logic             hit_open,
    output logic [CNT_W-1:0] pos,
    output logic             door_open,
    output logic             alarm
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_LEN - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] prog;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == PH_ENTRY && key_stb) begin
            if (hit_pos) begin
                if (st_q.prog == LAST) begin
                    st_d.phase = PH_OPEN;
                    st_d.prog  = '0;
                end else begin
                    st_d.prog = st_q.prog + 1'b1;
                end
            end else if (!night && hit_open) begin
                st_d.phase = PH_OPEN;
                st_d.prog  = '0;
            end else if (night) begin
                st_d.phase = PH_ALARM;
                st_d.prog  = '0;
            end else begin
                st_d.prog = hit_first ? CNT_W'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{phase: PH_ENTRY, prog: '0};
        else     st_q <= st_d;
    end

    assign pos       = st_q.prog;
    assign door_open = (st_q.phase == PH_OPEN);
    assign alarm     = (st_q.phase == PH_ALARM);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !key_stb |=> ($stable(pos) && $stable(door_open) && $stable(alarm)));

    a_r3_day_open_key: assert property (@(posedge clk) disable iff (rst)
        (!door_open && !alarm && key_stb && !night && hit_open && !hit_pos) |=> door_open);

    a_r4_night_wrong: assert property (@(posedge clk) disable iff (rst)
        (!door_open && !alarm && key_stb && night && !hit_pos) |=> alarm);

    a_r5_day_restart: assert property (@(posedge clk) disable iff (rst)
        (!door_open && !alarm && key_stb && !night && !hit_pos && !hit_open)
        |=> (!alarm && !door_open && pos == ($past(hit_first) ? CNT_W'(1) : CNT_W'(0))));

    a_r6_open_holds: assert property (@(posedge clk) disable iff (rst)
        door_open |=> (door_open && !alarm));

    a_r7_alarm_holds: assert property (@(posedge clk) disable iff (rst)
        alarm |=> (alarm && !door_open));

    a_r8_reset_idle: assert property (@(posedge clk)
        rst |=> (pos == '0 && !door_open && !alarm));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(door_open && alarm));
endmodule

// File: rtl/entry_lock.sv
module entry_lock #(
    parameter int KEY_W    = 4,
    parameter int CODE_LEN = 5,
    parameter logic [CODE_LEN*KEY_W-1:0] ACCESS_CODE = 20'h53A17,
    parameter logic [KEY_W-1:0] OPEN_KEY = 4'hF
) (
    input  logic             clk,
    input  logic             timeout_rst,
    input  logic             key_stb,
    input  logic             night_mode,
    input  logic [KEY_W-1:0] key_code,
    output logic             door_open,
    output logic             alarm
);
    localparam int CNT_W = $clog2(CODE_LEN + 1);

    logic [CNT_W-1:0] pos;
    logic             hit_pos, hit_first, hit_open;

    lock_key_match #(
        .KEY_W(KEY_W), .CODE_LEN(CODE_LEN), .CNT_W(CNT_W),
        .ACCESS_CODE(ACCESS_CODE), .OPEN_KEY(OPEN_KEY)
    ) u_match (
        .key(key_code), .pos(pos),
        .hit_pos(hit_pos), .hit_first(hit_first), .hit_open(hit_open)
    );

    lock_seq_fsm #(.CODE_LEN(CODE_LEN), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst(timeout_rst), .key_stb(key_stb), .night(night_mode),
        .hit_pos(hit_pos), .hit_first(hit_first), .hit_open(hit_open),
        .pos(pos), .door_open(door_open), .alarm(alarm)
    );
endmodule

// File: tb/entry_lock_test.sv
module entry_lock_test;
    localparam int PERIOD = 100;

    logic       clk = 0;
    logic       timeout_rst = 1;
    logic       key_stb = 0;
    logic       night_mode = 0;
    logic [3:0] key_code = 0;
    logic       door_open, alarm;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    int code [5] = '{5, 3, 10, 1, 7};

    entry_lock uut (
        .clk(clk), .timeout_rst(timeout_rst), .key_stb(key_stb),
        .night_mode(night_mode), .key_code(key_code),
        .door_open(door_open), .alarm(alarm)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        timeout_rst = 1;
        key_stb = 0;
        @(negedge clk);
        timeout_rst = 0;
    endtask

    task automatic press(input int k, input bit nm);
        @(negedge clk);
        key_code = 4'(k);
        night_mode = nm;
        key_stb = 1;
        @(negedge clk);
        key_stb = 0;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R8 reset door", int'(door_open), 0);
        chk("R8 reset alarm", int'(alarm), 0);

        // sweep: every key at every position, both modes
        for (int p = 0; p < 5; p++) begin
            for (int k = 0; k < 16; k++) begin
                for (int m = 0; m < 2; m++) begin
                    int ep;
                    int ph; // 0 entry, 1 open, 2 alarm
                    do_reset();
                    for (int i = 0; i < p; i++) press(code[i], 1'b1);
                    press(k, m[0]);
                    ep = 0;
                    ph = 0;
                    if (k == code[p]) begin
                        ep = p + 1;
                        if (ep == 5) ph = 1;
                    end else if (m == 0 && k == 15) ph = 1;       // R3
                    else if (m == 1) ph = 2;                       // R4
                    else ep = (k == 5) ? 1 : 0;                    // R5
                    chk($sformatf("R1/R3/R4 door p=%0d k=%0d night=%0d", p, k, m),
                        int'(door_open), int'(ph == 1));
                    chk($sformatf("R4/R5/R9 alarm p=%0d k=%0d night=%0d", p, k, m),
                        int'(alarm), int'(ph == 2));
                    if (ph == 0) begin
                        for (int i = ep; i < 5; i++) begin
                            chk("R1 door early", int'(door_open), 0);
                            press(code[i], 1'b1);
                        end
                        chk($sformatf("R5 progress finish p=%0d k=%0d night=%0d", p, k, m),
                            int'(door_open && !alarm), 1);
                    end else if (ph == 1) begin
                        press(0, 1'b1);
                        press(15, 1'b0);
                        chk("R6 open holds", int'(door_open && !alarm), 1);
                    end else begin
                        for (int i = 0; i < 5; i++) press(code[i], 1'b1);
                        press(15, 1'b0);
                        chk("R7 alarm holds", int'(alarm && !door_open), 1);
                    end
                end
            end
        end

        // R2: no strobe, wrong key held in night mode
        do_reset();
        press(5, 1'b1);
        @(negedge clk);
        key_code = 4'd9;
        night_mode = 1;
        repeat (6) @(negedge clk);
        chk("R2 no strobe alarm", int'(alarm), 0);
        chk("R2 no strobe door", int'(door_open), 0);
        for (int i = 1; i < 5; i++) press(code[i], 1'b1);
        chk("R2 progress kept", int'(door_open), 1);

        // R8: reset out of open and alarm
        do_reset();
        chk("R8 from open", int'(door_open), 0);
        press(2, 1'b1);
        chk("R7 alarm set", int'(alarm), 1);
        repeat (4) @(negedge clk);
        chk("R7 alarm idle hold", int'(alarm), 1);
        do_reset();
        chk("R8 from alarm", int'(alarm), 0);
        for (int i = 0; i < 5; i++) press(code[i], 1'b0);
        chk("R1 day full code", int'(door_open), 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule